// File: doc/BRIEF.md
# Cell Grant Handshake Receiver

This block is the receiving end of a word-parallel cell interface. A sender may start a cell only after the receiver offers a one-cycle grant. The sender answers in the very next cycle with a one-cycle valid pulse. That pulse commits a whole cell, which then arrives one 40-bit word (five octets) per clock. The sender does not signal the word count. The receiver derives it from a cell-size selector and counts the words itself.

Captured words land in a local cell FIFO. Downstream logic drains the FIFO through a show-ahead read port. A grant is offered only when the FIFO has room for a complete cell of the selected size. While the receiver is idle and has room, it re-offers the grant on a fixed four-cycle cadence until the sender takes it. A valid pulse that arrives anywhere other than the cycle after a grant is dropped and recorded in a sticky error flag.

The controller is a four-state machine:

- **HOLD**: the cadence wait state.
- **GRANT**: the grant is high for this one cycle.
- **ARMED**: the single cycle in which valid is legal.
- **CAPTURE**: the remaining words of the cell are written.

Its transitions are:

- HOLD→GRANT, when the wait is over and there is room.
- GRANT→ARMED, always.
- ARMED→CAPTURE, on valid.
- ARMED→HOLD, when the offer lapses.
- CAPTURE→HOLD, after the last word.

Top module: `cgr_receiver`

## Requirements
- R1: `rst` is synchronous and active high. While it is high, and on leaving it, `grant`, `proto_err`, `rd_avail` and `fill_level` are all 0. The first grant appears in the cycle after the second rising edge following the release of reset.
- R2: While the receiver is idle with enough free space, `grant` is high for exactly one cycle in every four. The four-cycle spacing also holds when an offer lapses without a valid pulse.
- R3: `size_sel` selects the cell length as follows: 0 gives 75 octets (15 words), 1 gives 79 (16), 2 gives 83 (17) and 3 gives 91 (19). The selector is sampled at the clock edge that raises the grant. A later change does not alter the cell already offered.
- R4: A valid pulse in the cycle right after a grant cycle writes `cell_data` of that cycle as word 0. It also writes `cell_data` of each of the following (words−1) cycles, in order, and nothing more.
- R5: `grant` stays low while a cell is being captured. When the receiver is idle, the next grant follows two cycles after the cycle that carried the last word.
- R6: No grant is offered while the free FIFO space, in words, is below the word count of the currently selected size.
- R7: A valid pulse outside the armed cycle writes nothing. It sets `proto_err`, which stays high until reset.
- R8: The read port works as follows. When `rd_avail` is 1, `rd_data` shows the oldest stored word. `rd_en` removes that word at the next edge. `rd_en` has no effect on an empty FIFO.
- R9: `fill_level` equals the number of stored words. Draining enough words to restore room for a cell lets the grant resume within one cadence period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| size_sel | input | 2 | Cell size selector (see R3) |
| cell_valid | input | 1 | One-cycle pulse from the sender that commits a cell |
| cell_data | input | 40 | Cell word bus, five octets per cycle |
| grant | output | 1 | One-cycle offer allowing the sender to start a cell |
| proto_err | output | 1 | Sticky flag for a stray valid pulse |
| rd_en | input | 1 | Pop the oldest FIFO word |
| rd_data | output | 40 | Oldest FIFO word (show-ahead) |
| rd_avail | output | 1 | FIFO holds at least one word |
| fill_level | output | 6 | Number of words stored in the FIFO |

## Verification
The bench measures grant spacing after reset, after a lapsed offer and after a finished cell. An off-by-one in the hold counter would show as a three- or five-cycle cadence. Every size code is run and the word count is verified. The bench also changes the selector between grant and valid, so a receiver that sampled the size late would store 19 words instead of 15. The FIFO is filled to just below one cell of room and then drained one word at a time; a wrong free-space comparison would grant into a FIFO that could overflow, or never grant again. Stray valid pulses are sent both in the idle wait and in the grant cycle itself. A receiver that accepted either would write words and leave the error flag low.

// File: rtl/cgr_pkg.sv
package cgr_pkg;

    typedef enum logic [1:0] {
        CS_75 = 2'd0,
        CS_79 = 2'd1,
        CS_83 = 2'd2,
        CS_91 = 2'd3
    } cell_size_e;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_GRANT   = 2'd1,
        ST_ARMED   = 2'd2,
        ST_CAPTURE = 2'd3
    } grant_state_e;

    function automatic int unsigned cell_octets(cell_size_e s);
        int unsigned n;
        unique case (s)
            CS_75: n = 75;
            CS_79: n = 79;
            CS_83: n = 83;
            CS_91: n = 91;
        endcase
        return n;
    endfunction

    function automatic int unsigned cell_words(cell_size_e s, int unsigned octets_per_word);
        return (cell_octets(s) + octets_per_word - 1) / octets_per_word;
    endfunction

endpackage

// File: rtl/cgr_cell_fifo.sv
module cgr_cell_fifo #(
    parameter int unsigned WORD_W = 40,
    parameter int unsigned DEPTH  = 32,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_avail,
    output logic [LVL_W-1:0]  level
);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr;
    logic [PTR_W-1:0]  rptr;
    logic [LVL_W-1:0]  count;
    logic              pop;
    logic              full;

    assign rd_avail = (count != '0);
    assign full     = (count == LVL_W'(DEPTH));
    assign pop      = rd_en && rd_avail;
    assign rd_data  = mem[rptr];
    assign level    = count;

    function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_en) begin
                wptr <= ptr_inc(wptr);
            end
            if (pop) begin
                rptr <= ptr_inc(rptr);
            end
            unique case ({wr_en, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !full);

    // R9
    level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !pop) |=> $stable(count));

    // R8
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_avail && !wr_en) |=> (count == '0));

endmodule

// File: rtl/cgr_beat_counter.sv
module cgr_beat_counter
    import cgr_pkg::*;
#(
    parameter int unsigned OCTETS_PER_WORD = 5,
    localparam int unsigned MAX_WORDS = cell_words(CS_91, OCTETS_PER_WORD),
    localparam int unsigned CNT_W = $clog2(MAX_WORDS + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  cell_size_e size_in,
    input  logic       start,
    input  logic       step,
    output cell_size_e size_q,
    output logic       rem_last
);

    logic [CNT_W-1:0] rem;
    logic [CNT_W-1:0] words_latched;

    assign words_latched = CNT_W'(cell_words(size_q, OCTETS_PER_WORD));
    assign rem_last      = (rem == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            size_q <= CS_75;
        end else if (load) begin
            size_q <= size_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem <= '0;
        end else if (start) begin
            rem <= words_latched - 1'b1;
        end else if (step && rem != '0) begin
            rem <= rem - 1'b1;
        end
    end

    // R4
    rem_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        step |-> (rem != '0));

    // R3
    size_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (start || step) |=> $stable(size_q));

endmodule

// File: rtl/cgr_grant_fsm.sv
module cgr_grant_fsm
    import cgr_pkg::*;
#(
    parameter int unsigned CADENCE = 4,
    localparam int unsigned HOLD_CYCLES = CADENCE - 2,
    localparam int unsigned HC_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic cell_valid,
    input  logic room_ok,
    input  logic rem_last,
    output logic grant,
    output logic offer_load,
    output logic cap_start,
    output logic cap_step,
    output logic wr_en,
    output logic proto_err
);

    grant_state_e state;
    grant_state_e state_nx;
    logic [HC_W-1:0] hold_cnt;
    logic            hold_done;
    logic            stray;

    assign hold_done = (hold_cnt == HC_W'(HOLD_CYCLES - 1));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HOLD:    if (hold_done && room_ok) state_nx = ST_GRANT;
            ST_GRANT:   state_nx = ST_ARMED;
            ST_ARMED:   state_nx = cell_valid ? ST_CAPTURE : ST_HOLD;
            ST_CAPTURE: if (rem_last) state_nx = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_HOLD;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= '0;
        end else if (state != ST_HOLD || state_nx != ST_HOLD) begin
            hold_cnt <= '0;
        end else if (!hold_done) begin
            hold_cnt <= hold_cnt + 1'b1;
        end
    end

    always_comb begin
        grant      = 1'b0;
        offer_load = 1'b0;
        cap_start  = 1'b0;
        cap_step   = 1'b0;
        stray      = cell_valid;
        unique case (state)
            ST_HOLD:    offer_load = (state_nx == ST_GRANT);
            ST_GRANT:   grant = 1'b1;
            ST_ARMED: begin
                cap_start = cell_valid;
                stray     = 1'b0;
            end
            ST_CAPTURE: cap_step = 1'b1;
        endcase
        wr_en = cap_start || cap_step;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            proto_err <= 1'b0;
        end else if (stray) begin
            proto_err <= 1'b1;
        end
    end

    // R2
    grant_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        grant |=> !grant);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);

    // R4
    armed_follows_grant_chk: assert property (@(posedge clk) disable iff (rst)
        cap_start |-> $past(grant));

endmodule

// File: rtl/cgr_receiver.sv
module cgr_receiver
    import cgr_pkg::*;
#(
    parameter int unsigned WORD_W  = 40,
    parameter int unsigned DEPTH   = 32,
    parameter int unsigned CADENCE = 4,
    localparam int unsigned OCTETS_PER_WORD = WORD_W / 8,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        size_sel,
    input  logic              cell_valid,
    input  logic [WORD_W-1:0] cell_data,
    output logic              grant,
    output logic              proto_err,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_avail,
    output logic [LVL_W-1:0]  fill_level
);

    cell_size_e       size_now;
    cell_size_e       size_q;
    logic [LVL_W-1:0] free_words;
    logic [LVL_W-1:0] need_now;
    logic [LVL_W-1:0] need_latched;
    logic             room_ok;
    logic             offer_load;
    logic             cap_start;
    logic             cap_step;
    logic             rem_last;
    logic             fifo_wr;

    assign size_now     = cell_size_e'(size_sel);
    assign free_words   = LVL_W'(DEPTH) - fill_level;
    assign need_now     = LVL_W'(cell_words(size_now, OCTETS_PER_WORD));
    assign need_latched = LVL_W'(cell_words(size_q, OCTETS_PER_WORD));
    assign room_ok      = (free_words >= need_now);

    cgr_grant_fsm #(.CADENCE(CADENCE)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cell_valid (cell_valid),
        .room_ok    (room_ok),
        .rem_last   (rem_last),
        .grant      (grant),
        .offer_load (offer_load),
        .cap_start  (cap_start),
        .cap_step   (cap_step),
        .wr_en      (fifo_wr),
        .proto_err  (proto_err)
    );

    cgr_beat_counter #(.OCTETS_PER_WORD(OCTETS_PER_WORD)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (offer_load),
        .size_in  (size_now),
        .start    (cap_start),
        .step     (cap_step),
        .size_q   (size_q),
        .rem_last (rem_last)
    );

    cgr_cell_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (fifo_wr),
        .wr_data  (cell_data),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rd_avail (rd_avail),
        .level    (fill_level)
    );

    // R6
    grant_room_chk: assert property (@(posedge clk) disable iff (rst)
        grant |-> (free_words >= need_latched));

    // R5
    no_grant_in_capture_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> !grant);

    // R7
    stray_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cell_valid && !$past(grant)) |-> !fifo_wr);

endmodule

// File: tb/tb_cgr_receiver.sv
module tb_cgr_receiver;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;

    // vector: {size_sel[1:0], expected words[4:0]}
    localparam logic [6:0] VEC [4] = '{
        {2'd0, 5'd15}, {2'd1, 5'd16}, {2'd2, 5'd17}, {2'd3, 5'd19}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  size_sel = 2'd0;
    logic        cell_valid = 1'b0;
    logic [39:0] cell_data = '0;
    logic        grant;
    logic        proto_err;
    logic        rd_en = 1'b0;
    logic [39:0] rd_data;
    logic        rd_avail;
    logic [5:0]  fill_level;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    cgr_receiver dut (
        .clk        (clk),
        .rst        (rst),
        .size_sel   (size_sel),
        .cell_valid (cell_valid),
        .cell_data  (cell_data),
        .grant      (grant),
        .proto_err  (proto_err),
        .rd_en      (rd_en),
        .rd_data    (rd_data),
        .rd_avail   (rd_avail),
        .fill_level (fill_level)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_LIMIT) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than %0d", cyc, WD_LIMIT);
            summary();
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [39:0] word_of(input int id, input int i);
        return {id[7:0], 32'hC0DE_0000 + 32'(i)};
    endfunction

    task automatic do_reset;
        rst = 1'b1;
        cell_valid = 1'b0;
        rd_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_grant(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!grant && n < 40);
    endtask

    // called at the negedge where grant is seen high
    task automatic send_cell(input int id, input int words);
        bit grant_seen = 1'b0;
        @(negedge clk);
        cell_valid = 1'b1;
        cell_data  = word_of(id, 0);
        for (int i = 1; i < words; i++) begin
            @(negedge clk);
            if (grant) grant_seen = 1'b1;
            cell_valid = 1'b0;
            cell_data  = word_of(id, i);
        end
        @(negedge clk);
        if (grant) grant_seen = 1'b1;
        cell_valid = 1'b0;
        cell_data  = '0;
        // R5
        check(!grant_seen, "R5", "grant during capture", grant_seen, 0);
    endtask

    task automatic drain(input int id, input int words);
        bit bad = 1'b0;
        logic [39:0] first_bad = '0;
        logic [39:0] first_exp = '0;
        for (int i = 0; i < words; i++) begin
            if (!bad && (!rd_avail || rd_data !== word_of(id, i))) begin
                bad = 1'b1;
                first_bad = rd_data;
                first_exp = word_of(id, i);
            end
            rd_en = 1'b1;
            @(negedge clk);
        end
        rd_en = 1'b0;
        // R4 R8
        check(!bad, "R4/R8", "stored word order", first_bad, first_exp);
    endtask

    task automatic expect_no_grant(input int cycles, input string req);
        bit seen = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (grant) seen = 1'b1;
        end
        check(!seen, req, "grant withheld", seen, 0);
    endtask

    initial begin
        int n;
        int exp_words;

        // R1 reset state
        repeat (3) @(negedge clk);
        check(grant == 0 && proto_err == 0 && fill_level == 0 && rd_avail == 0,
              "R1", "outputs in reset", {grant, proto_err, rd_avail, fill_level}, 0);
        rst = 1'b0;
        wait_grant(n);
        check(n == 2, "R1", "first grant delay", n, 2);

        // R2 cadence, offers lapse
        wait_grant(n);
        check(n == 4, "R2", "cadence gap 1", n, 4);
        wait_grant(n);
        check(n == 4, "R2", "cadence gap 2", n, 4);
        check(proto_err == 0, "R2", "no error on lapse", proto_err, 0);

        // R3 R4 vector table over all sizes
        for (int v = 0; v < 4; v++) begin
            do_reset();
            size_sel  = VEC[v][6:5];
            exp_words = int'(VEC[v][4:0]);
            wait_grant(n);
            send_cell(v + 1, exp_words);
            check(fill_level == 6'(exp_words), "R3", "words per size",
                  fill_level, exp_words);
            repeat (3) @(negedge clk);
            check(fill_level == 6'(exp_words), "R4", "no extra words",
                  fill_level, exp_words);
            drain(v + 1, exp_words);
            check(fill_level == 0 && rd_avail == 0, "R9", "empty after drain",
                  fill_level, 0);
        end

        // R3 size sampled at grant edge
        do_reset();
        size_sel = 2'd0;
        wait_grant(n);
        size_sel = 2'd3;
        send_cell(9, 15);
        repeat (4) @(negedge clk);
        check(fill_level == 15, "R3", "size latched at grant", fill_level, 15);

        // R6 one 91-octet cell leaves 13 free
        do_reset();
        size_sel = 2'd3;
        wait_grant(n);
        send_cell(5, 19);
        check(fill_level == 19, "R6", "fill after big cell", fill_level, 19);
        expect_no_grant(12, "R6");
        size_sel = 2'd0;
        expect_no_grant(8, "R6");
        // R9 draining two words gives room for 15
        rd_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        check(fill_level == 17, "R9", "fill after pops", fill_level, 17);
        wait_grant(n);
        check(n <= 4, "R9", "grant resumes", n, 4);

        // R6 R5 two small cells
        do_reset();
        size_sel = 2'd0;
        wait_grant(n);
        send_cell(6, 15);
        wait_grant(n);
        check(n == 2, "R5", "regrant after capture", n, 2);
        send_cell(7, 15);
        check(fill_level == 30, "R6", "fill after two cells", fill_level, 30);
        expect_no_grant(12, "R6");

        // R7 stray valid in hold
        do_reset();
        cell_valid = 1'b1;
        cell_data  = 40'hDEAD;
        @(negedge clk);
        cell_valid = 1'b0;
        check(proto_err == 1, "R7", "error on stray", proto_err, 1);
        check(fill_level == 0, "R7", "stray not written", fill_level, 0);
        repeat (10) @(negedge clk);
        check(proto_err == 1, "R7", "error sticky", proto_err, 1);

        // R7 valid during the grant cycle itself
        do_reset();
        wait_grant(n);
        cell_valid = 1'b1;
        @(negedge clk);
        cell_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(proto_err == 1 && fill_level == 0, "R7", "valid in grant cycle",
              {proto_err, fill_level}, 7'h40);
        do_reset();
        @(negedge clk);
        check(proto_err == 0, "R1", "reset clears error", proto_err, 0);

        // R8 pop on empty
        rd_en = 1'b1;
        repeat (3) @(negedge clk);
        rd_en = 1'b0;
        check(fill_level == 0 && rd_avail == 0, "R8", "pop on empty ignored",
              fill_level, 0);

        summary();
    end

endmodule